// File: doc/BRIEF.md
# Prefix-Extended Stack-Relative Load Unit

This block carries out a halfword load whose address is a 24-bit stack pointer plus an unsigned displacement. It accepts decoded instruction words one per handshake on a valid/ready input. A word is tagged as a prefix, a load or some other instruction. Prefix words are remembered, and the last two of them widen the displacement that the next load uses. A load issues a one-cycle read strobe to a simple memory port. It then writes the 16-bit result, zero-extended to 24 bits, into one of eight general registers.

The input stream follows valid/ready rules. A word is taken on a rising edge when `in_valid` and `in_ready` are both high. `in_ready` stays low from the edge that takes a load until the edge that ends its write-back, and that is the only back-pressure. Once `in_valid` is raised it should hold steady until the word is taken. Prefixes and other words are taken in a single cycle and never stall. When the effective address is odd, a misalignment request pulses, and the read still goes out with bit 0 cleared. A load that sits in a branch delay slot ignores any pending prefixes.

Top module: `stack_load_unit`

## Requirements
- R1: After reset, `in_ready` is 1 and `mem_req`, `wb_en` and `misalign_irq` are 0.
- R2: A load is tagged `in_kind`=2. It carries the destination register in word bits 9:7 and a 7-bit immediate in bits 6:0. With no pending prefix, the effective address is `sp` plus the zero-extended 7-bit immediate.
- R3: A prefix is tagged `in_kind`=1 and carries a 13-bit immediate in word bits 12:0. With one pending prefix, the displacement is {prefix imm13, load imm7}, which is 20 bits and zero-extended.
- R4: With two pending prefixes, the displacement is {older prefix bits 3:0, newer prefix imm13, load imm7}, which is 24 bits.
- R5: A third consecutive prefix displaces the oldest one, so only the last two prefixes shape the displacement.
- R6: Taking any non-prefix word clears the pending prefixes. This covers `in_kind` 0 or 3 as well as a load.
- R7: A load taken with `in_delay_slot`=1 uses only its 7-bit immediate, whatever prefixes are pending, and it also clears them.
- R8: `mem_req` is high for exactly the one cycle after the edge that takes a load. `wb_en` is high in the following cycle if `mem_rvalid` is high, and otherwise in the first later cycle in which `mem_rvalid` is high. `in_ready` is low from the cycle after the load is taken through the write-back cycle.
- R9: During write-back, `wb_sel` equals the load's destination field and `wb_data` equals {8'h00, `mem_rdata`}.
- R10: When the effective address is odd, `misalign_irq` is high in the `mem_req` cycle, and `mem_addr` is the effective address with bit 0 cleared. When the effective address is even, `misalign_irq` stays low.
- R11: The address sum wraps modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can take a word |
| in_kind | input | 2 | 0 other, 1 prefix, 2 load, 3 other |
| in_word | input | 16 | Decoded instruction word |
| in_delay_slot | input | 1 | Word occupies a branch delay slot |
| sp | input | 24 | Stack pointer, sampled when a load is taken |
| mem_req | output | 1 | Halfword read strobe |
| mem_addr | output | 24 | Read address, bit 0 always 0 |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| wb_en | output | 1 | Register write enable |
| wb_sel | output | 3 | Destination register r0..r7 |
| wb_data | output | 24 | Zero-extended loaded value |
| misalign_irq | output | 1 | Odd effective address request |

## Verification
A load taken at edge k shows its address, strobe and misalignment flag in the cycle that follows edge k. Its write-back appears one cycle later, at edge k+1, when the memory answers at once. For each of these, the bench counts edges from the take and samples on the falling edge of exactly that cycle. When the memory answer is held back, the bench first checks that no write-back and no readiness appear in the stalled cycle. It then raises `mem_rvalid` and expects the write-back in the same cycle. Prefix effects are judged only through the address of the next load.

// File: rtl/sld_pkg.sv
package sld_pkg;
  typedef enum logic [1:0] {
    K_OTHER  = 2'd0,
    K_PREFIX = 2'd1,
    K_LOAD   = 2'd2,
    K_OTHER3 = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } lstate_e;

  localparam int LO_W  = 7;
  localparam int MID_W = 13;
endpackage

// File: rtl/sld_prefix_track.sv
module sld_prefix_track #(
  parameter int DEPTH = 2,
  parameter int IMM_W = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take,
  input  logic                          is_prefix,
  input  logic [IMM_W-1:0]              imm,
  output logic [$clog2(DEPTH+1)-1:0]    cnt,
  output logic [DEPTH-1:0][IMM_W-1:0]   slots
);
  localparam int CW = $clog2(DEPTH+1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (take) begin
      if (!is_prefix)               cnt <= '0;
      else if (cnt != CW'(DEPTH))   cnt <= cnt + 1'b1;
    end
  end

  // slot 0 is the newest prefix; older ones move up on each new prefix
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slots[0] <= '0;
    else if (take && is_prefix) slots[0] <= imm;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_shift
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slots[g] <= '0;
      else if (take && is_prefix) slots[g] <= slots[g-1];
    end
  end
endmodule

// File: rtl/sld_disp_build.sv
module sld_disp_build #(
  parameter int AW    = 24,
  parameter int LO_W  = 7,
  parameter int MID_W = 13
) (
  input  logic [1:0]           cnt,
  input  logic                 delay_slot,
  input  logic [MID_W-1:0]     newer,
  input  logic [MID_W-1:0]     older,
  input  logic [LO_W-1:0]      imm_lo,
  output logic [AW-1:0]        disp
);
  localparam int HI_W = AW - LO_W - MID_W;

  always_comb begin
    disp = '0;
    disp[LO_W-1:0] = imm_lo;
    if (!delay_slot && cnt != 2'd0) begin
      disp[LO_W +: MID_W] = newer;
      if (cnt == 2'd2) disp[LO_W+MID_W +: HI_W] = older[HI_W-1:0];
    end
  end
endmodule

// File: rtl/sld_seq.sv
module sld_seq
  import sld_pkg::*;
#(
  parameter int AW = 24,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] ea,
  input  logic [SW-1:0] sel,
  input  logic          rvalid,
  output logic          idle,
  output logic          req,
  output logic          wb,
  output logic [AW-1:0] addr,
  output logic          odd,
  output logic [SW-1:0] sel_q
);
  lstate_e       st;
  logic [AW-1:0] ea_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ea_q  <= '0;
      sel_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st    <= S_REQ;
          ea_q  <= ea;
          sel_q <= sel;
        end
        S_REQ:   st <= S_WAIT;
        S_WAIT:  if (rvalid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign idle = (st == S_IDLE);
  assign req  = (st == S_REQ);
  assign wb   = (st == S_WAIT) && rvalid;
  assign addr = {ea_q[AW-1:1], 1'b0};
  assign odd  = req && ea_q[0];
endmodule

// File: rtl/stack_load_unit.sv
module stack_load_unit
  import sld_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int NREG  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_kind,
  input  logic [15:0]   in_word,
  input  logic          in_delay_slot,
  input  logic [AW-1:0] sp,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          wb_en,
  output logic [2:0]    wb_sel,
  output logic [AW-1:0] wb_data,
  output logic          misalign_irq
);
  localparam int SW    = $clog2(NREG);
  localparam int DEPTH = 2;

  logic                       take, is_pfx, is_ld;
  logic [1:0]                 pcnt;
  logic [DEPTH-1:0][MID_W-1:0] pslots;
  logic [AW-1:0]              disp, ea;
  logic                       idle;

  assign take   = in_valid && in_ready;
  assign is_pfx = (kind_e'(in_kind) == K_PREFIX);
  assign is_ld  = take && (kind_e'(in_kind) == K_LOAD);

  sld_prefix_track #(.DEPTH(DEPTH), .IMM_W(MID_W)) u_pfx (
    .clk(clk), .rst_n(rst_n), .take(take), .is_prefix(is_pfx),
    .imm(in_word[MID_W-1:0]), .cnt(pcnt), .slots(pslots)
  );

  sld_disp_build #(.AW(AW), .LO_W(LO_W), .MID_W(MID_W)) u_disp (
    .cnt(pcnt), .delay_slot(in_delay_slot), .newer(pslots[0]),
    .older(pslots[1]), .imm_lo(in_word[LO_W-1:0]), .disp(disp)
  );

  assign ea = sp + disp;

  sld_seq #(.AW(AW), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(is_ld), .ea(ea),
    .sel(in_word[LO_W +: SW]), .rvalid(mem_rvalid), .idle(idle),
    .req(mem_req), .wb(wb_en), .addr(mem_addr), .odd(misalign_irq),
    .sel_q(wb_sel)
  );

  assign in_ready = idle;
  assign wb_data  = {{(AW-DW){1'b0}}, mem_rdata};
endmodule

// File: rtl/sld_chk.sv
module sld_chk #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          wb_en,
  input logic [AW-1:0] wb_data,
  input logic          misalign_irq
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R8
  AST_REQ_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !in_ready); // R8
  AST_WB_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) wb_en |-> !in_ready); // R8
  AST_REQ_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !mem_rvalid |=> !in_ready); // R8
  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !mem_addr[0]); // R10
  AST_IRQ_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n) misalign_irq |-> mem_req); // R10
  AST_WB_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n) wb_en |-> wb_data[AW-1:DW] == '0); // R9
endmodule

bind stack_load_unit sld_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .wb_en(wb_en),
  .wb_data(wb_data), .misalign_irq(misalign_irq)
);

// File: tb/tb_stack_load_unit.sv
module tb_stack_load_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_delay_slot = 0, mem_rvalid = 0;
  logic [1:0]  in_kind = 0;
  logic [15:0] in_word = 0, mem_rdata = 0;
  logic [23:0] sp = 0;
  logic        in_ready, mem_req, wb_en, misalign_irq;
  logic [23:0] mem_addr, wb_data;
  logic [2:0]  wb_sel;
  int checks = 0, fails = 0;
  bit done = 0;

  stack_load_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] k, logic [15:0] w, logic ds);
    @(negedge clk);
    in_valid = 1; in_kind = k; in_word = w; in_delay_slot = ds;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_delay_slot = 0;
  endtask

  // issue a load and check its address, flag and write-back
  task automatic do_load(string req, logic [23:0] s, logic [2:0] rd,
                         logic [6:0] imm, logic ds, logic [23:0] ea,
                         logic [15:0] dat, bit stall);
    @(negedge clk);
    sp = s; in_valid = 1; in_kind = 2'd2; in_word = {6'd0, rd, imm};
    in_delay_slot = ds;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_delay_slot = 0;
    chk({req, " req"}, mem_req, 1);
    chk({req, " addr"}, mem_addr, {ea[23:1], 1'b0});
    chk({req, " R10 irq"}, misalign_irq, ea[0]);
    chk({req, " R8 ready"}, in_ready, 0);
    mem_rdata = dat; mem_rvalid = !stall;
    @(posedge clk);
    @(negedge clk);
    chk({req, " R8 req drop"}, mem_req, 0);
    if (stall) begin
      chk({req, " R8 stall wb"}, wb_en, 0);
      chk({req, " R8 stall ready"}, in_ready, 0);
      mem_rvalid = 1;
      #1;
    end
    chk({req, " R8 wb"}, wb_en, 1);
    chk({req, " R9 sel"}, wb_sel, rd);
    chk({req, " R9 data"}, wb_data, {8'h00, dat});
    @(posedge clk);
    @(negedge clk);
    mem_rvalid = 0;
    chk({req, " R8 ready back"}, in_ready, 1);
  endtask

  task automatic t_reset();
    chk("R1 ready", in_ready, 1);
    chk("R1 req", mem_req, 0);
    chk("R1 wb", wb_en, 0);
    chk("R1 irq", misalign_irq, 0);
  endtask

  task automatic t_noprefix();
    do_load("R2", 24'h001000, 3'd3, 7'h54, 0, 24'h001054, 16'h1234, 0);
  endtask

  task automatic t_oneprefix();
    send(2'd1, 16'h0001, 0);
    do_load("R3", 24'h000100, 3'd0, 7'h02, 0, 24'h000100 + 24'h82, 16'hA5A5, 0);
  endtask

  task automatic t_twoprefix();
    send(2'd1, 16'h1FF5, 0);
    send(2'd1, 16'h0ABC, 0);
    do_load("R4", 24'h000010, 3'd7, 7'h06, 0,
            24'h000010 + ((24'h5 << 20) | (24'hABC << 7) | 24'h06), 16'h0F0F, 0);
  endtask

  task automatic t_threeprefix();
    send(2'd1, 16'h000E, 0);
    send(2'd1, 16'h0003, 0);
    send(2'd1, 16'h0010, 0);
    do_load("R5", 24'h000000, 3'd1, 7'h00, 0,
            (24'h3 << 20) | (24'h10 << 7), 16'h4444, 0);
  endtask

  task automatic t_clear();
    send(2'd1, 16'h0123, 0);
    send(2'd0, 16'h0FFF, 0);
    do_load("R6", 24'h000200, 3'd2, 7'h10, 0, 24'h000210, 16'h5555, 0);
    send(2'd1, 16'h0123, 0);
    do_load("R6 load", 24'h000000, 3'd2, 7'h00, 0, 24'h123 << 7, 16'h5656, 0);
    do_load("R6 after", 24'h000000, 3'd2, 7'h08, 0, 24'h000008, 16'h5757, 0);
  endtask

  task automatic t_delay();
    send(2'd1, 16'h0044, 0);
    send(2'd1, 16'h0002, 0);
    do_load("R7", 24'h000300, 3'd4, 7'h20, 1, 24'h000320, 16'h6666, 0);
    do_load("R7 cleared", 24'h000300, 3'd4, 7'h22, 0, 24'h000322, 16'h6767, 0);
  endtask

  task automatic t_stall();
    do_load("R8 stall", 24'h000400, 3'd5, 7'h0C, 0, 24'h00040C, 16'hBEEF, 1);
  endtask

  task automatic t_odd();
    do_load("R10 odd", 24'h000500, 3'd6, 7'h33, 0, 24'h000533, 16'hCAFE, 0);
  endtask

  task automatic t_wrap();
    do_load("R11", 24'hFFFFF0, 3'd1, 7'h20, 0, 24'h000010, 16'h7777, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_noprefix();
    t_oneprefix();
    t_twoprefix();
    t_threeprefix();
    t_clear();
    t_delay();
    t_stall();
    t_odd();
    t_wrap();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule